// File: doc/BRIEF.md
# Segment-Offset Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. It keeps four segment registers: code, data, stack and extra. The segment value is moved up four bit positions, so every segment base lands on a 16-byte paragraph boundary. The offset, widened with zeros, is then added to it. Any carry above the top address bit is dropped, so a sum past the end of the 1 MiB space wraps around to the bottom. Several segment:offset pairs can therefore name the same byte.

For each request the caller gives an offset and a tag that says which register supplied that offset. Offsets from the instruction pointer always use the code segment. Offsets from the stack pointer or the base pointer use the stack segment by default. All other data offsets use the data segment by default. For a data access, an override can send the access to the data segment or to the extra segment instead. A write port loads the segment registers. The result is registered, one cycle after the request, and comes out with a valid flag and the identifier of the segment that was used.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `addr_valid`, `addr_out` and `addr_seg` are 0 and all four segment registers hold 0. A data request with offset 0x1234 made straight after reset therefore gives 0x01234.
- R2: A request presented with `req_valid` high at one rising edge gives `addr_valid` high after that edge. At the same time `addr_out` equals (segment × 16 + offset) modulo 2^20.
- R3: A carry out of bit 19 is discarded. Segment 0xFFFF with offset 0x4336 gives 0x04326.
- R4: Segment bases are paragraph aligned, so an offset of 0 always gives an address whose low four bits are 0. The pairs 1DDD:0100, 1DED:0000 and 1DCD:0200 all give 0x1DED0.
- R5: A request tagged as an instruction fetch (`req_src` = 0) always uses the code segment and reports `addr_seg` = 0, even when `ovr_en` is high.
- R6: With no override, a request tagged stack pointer (`req_src` = 1) or base pointer (`req_src` = 2) uses the stack segment and reports `addr_seg` = 2.
- R7: With no override, a request tagged general data (`req_src` = 3) uses the data segment and reports `addr_seg` = 1.
- R8: On a data request (`req_src` ≠ 0) with `ovr_en` high, `ovr_extra` = 0 selects the data segment (`addr_seg` = 1) and `ovr_extra` = 1 selects the extra segment (`addr_seg` = 3). This applies whatever the default would have been.
- R9: The segment identifier is the same on `wr_sel` and on `addr_seg`: 0 code, 1 data, 2 stack, 3 extra.
- R10: A segment write with `wr_en` high at one edge affects requests at later edges only. A request at the same edge uses the old value.
- R11: At an edge where `req_valid` is low, `addr_valid` goes low and `addr_out` and `addr_seg` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load a segment register |
| wr_sel | input | 2 | Segment register to load (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Translate the offset presented this cycle |
| req_offset | input | 16 | Offset to translate |
| req_src | input | 2 | Register that supplied the offset (0 instruction pointer, 1 stack pointer, 2 base pointer, 3 general data) |
| ovr_en | input | 1 | Segment override valid (data accesses only) |
| ovr_extra | input | 1 | Override target: 0 data segment, 1 extra segment |
| addr_valid | output | 1 | `addr_out` holds a fresh result |
| addr_out | output | 20 | Physical address |
| addr_seg | output | 2 | Segment used for `addr_out` |

## Verification
The hardest case to produce is a write and a request that reach the same edge and touch the same segment register. The result must reflect the old contents, and the new value may appear only on the next request. The stimulus drives `wr_en` and `req_valid` together in one cycle, with a different value already loaded, and then repeats the request alone. It also pairs the override with an instruction-fetch tag, which the selection logic must ignore. Finally it picks segment and offset values whose sum crosses bit 19, which exercises the wrap-around.

// File: rtl/seg_addr_pkg.sv
// Package: shared identifiers for the segment-offset address generator.
// Assumes two-bit encodings for both the segment identifier and the
// offset-source tag; the port encodings of the top module follow these.
package seg_addr_pkg;

    localparam int SEG_W_DEF   = 16;
    localparam int OFF_W_DEF   = 16;
    localparam int SHIFT_DEF   = 4;
    localparam int NUM_SEG     = 4;
    localparam int SEG_ID_W    = $clog2(NUM_SEG);

    typedef enum logic [SEG_ID_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        SRC_IPTR    = 2'd0,
        SRC_STKPTR  = 2'd1,
        SRC_BASEPTR = 2'd2,
        SRC_GENERAL = 2'd3
    } off_src_e;

endpackage

// File: rtl/seg_regfile.sv
// Module: seg_regfile
// Holds the segment registers. It has one synchronous write port and one
// combinational read port. A read in the same cycle as a write returns the
// value from before the write. Assumes a synchronous active-low reset,
// which clears every register to zero.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  seg_id_e          wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  seg_id_e          rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] seg_q [NUM_SEG];

    for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_seg
        // Load one register when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[gi] <= '0;
            end else if (wr_en && (wr_sel == seg_id_e'(gi))) begin
                seg_q[gi] <= wr_data;
            end
        end

        // R10
        seg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_sel == seg_id_e'(gi))) |=> (seg_q[gi] == $past(wr_data)));
    end

    // Return the addressed register.
    always_comb begin
        rd_data = seg_q[rd_sel];
    end

endmodule

// File: rtl/seg_select.sv
// Module: seg_select
// Picks the segment for an access from the offset-source tag and the
// override inputs. An instruction fetch always uses the code segment, and
// the override is ignored for it. For data accesses the default is the
// stack segment when the offset comes from a stack or base pointer, and
// the data segment otherwise. A valid override replaces that default with
// the data or the extra segment. Purely combinational.
module seg_select
    import seg_addr_pkg::*;
(
    input  off_src_e src_i,
    input  logic     ovr_en_i,
    input  logic     ovr_extra_i,
    output seg_id_e  seg_o
);

    seg_id_e dflt_seg;

    // Default segment from the offset source.
    always_comb begin
        unique case (src_i)
            SRC_IPTR:    dflt_seg = SEG_CODE;
            SRC_STKPTR,
            SRC_BASEPTR: dflt_seg = SEG_STACK;
            default:     dflt_seg = SEG_DATA;
        endcase
    end

    // Apply the override to data accesses only.
    always_comb begin
        if (src_i == SRC_IPTR) begin
            seg_o = SEG_CODE;
        end else if (ovr_en_i) begin
            seg_o = ovr_extra_i ? SEG_EXTRA : SEG_DATA;
        end else begin
            seg_o = dflt_seg;
        end
    end

endmodule

// File: rtl/seg_phys_adder.sv
// Module: seg_phys_adder
// Forms a physical address from a segment and an offset. The segment has
// SHIFT zero bits appended on the right, the offset is zero-extended, and
// the two are added at the segment width plus SHIFT. The carry out of the
// top bit is dropped, so the address wraps. Assumes OFF_W <= SEG_W + SHIFT.
module seg_phys_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  addr_o
);

    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] off_ext;

    // Align the segment to a paragraph, widen the offset, and add.
    always_comb begin
        base_ext = {seg_i, {SHIFT{1'b0}}};
        off_ext  = PA_W'(off_i);
        addr_o   = base_ext + off_ext;
    end

endmodule

// File: rtl/seg_phys_addr_gen.sv
// Module: seg_phys_addr_gen (top)
// Segment-offset physical address generator. It selects a segment,
// reads that segment register, adds the offset with wrap-around, and
// registers the address, the segment used and a valid flag. The result
// appears one cycle after the request. When there is no request the
// address and segment outputs hold and the valid flag drops. Synchronous
// active-low reset.
module seg_phys_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_ID_W-1:0] wr_sel,
    input  logic [SEG_W-1:0]    wr_data,
    input  logic                req_valid,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [1:0]          req_src,
    input  logic                ovr_en,
    input  logic                ovr_extra,
    output logic                addr_valid,
    output logic [PA_W-1:0]     addr_out,
    output logic [SEG_ID_W-1:0] addr_seg
);

    seg_id_e          sel_seg;
    logic [SEG_W-1:0] sel_val;
    logic [PA_W-1:0]  sum_addr;

    seg_select u_select (
        .src_i       (off_src_e'(req_src)),
        .ovr_en_i    (ovr_en),
        .ovr_extra_i (ovr_extra),
        .seg_o       (sel_seg)
    );

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (seg_id_e'(wr_sel)),
        .wr_data (wr_data),
        .rd_sel  (sel_seg),
        .rd_data (sel_val)
    );

    seg_phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_adder (
        .seg_i  (sel_val),
        .off_i  (req_offset),
        .addr_o (sum_addr)
    );

    // Register the result when a request is accepted; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
            addr_seg   <= '0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) begin
                addr_out <= sum_addr;
                addr_seg <= sel_seg;
            end
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(addr_out) && $stable(addr_seg)));

    // R4
    paragraph_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_offset == '0)) |=> (addr_out[SHIFT-1:0] == '0));

    // R5
    fetch_code_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_src == 2'd0)) |=> (addr_seg == 2'd0));

    // R6
    stack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_en && ((req_src == 2'd1) || (req_src == 2'd2)))
        |=> (addr_seg == 2'd2));

    // R7
    data_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_en && (req_src == 2'd3)) |=> (addr_seg == 2'd1));

    // R8
    override_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_en && (req_src != 2'd0))
        |=> (addr_seg == ($past(ovr_extra) ? 2'd3 : 2'd1)));

endmodule

// File: tb/test_seg_phys_addr_gen.sv
module test_seg_phys_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_offset = '0;
    logic [1:0]  req_src = '0;
    logic        ovr_en = 1'b0;
    logic        ovr_extra = 1'b0;
    logic        addr_valid;
    logic [19:0] addr_out;
    logic [1:0]  addr_seg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seg_phys_addr_gen i_seg_phys_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_offset(req_offset),
        .req_src(req_src), .ovr_en(ovr_en), .ovr_extra(ovr_extra),
        .addr_valid(addr_valid), .addr_out(addr_out), .addr_seg(addr_seg)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] t;
        t = {1'b0, s, 4'h0} + {5'h0, o};
        return t[19:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One request; results sampled at the negedge after the capturing edge.
    task automatic req(input logic [15:0] off, input logic [1:0] src,
                       input logic oe, input logic ox);
        @(negedge clk);
        req_valid = 1'b1; req_offset = off; req_src = src;
        ovr_en = oe; ovr_extra = ox;
        @(negedge clk);
        req_valid = 1'b0; ovr_en = 1'b0; ovr_extra = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [19:0] a, input logic [1:0] s);
        chk({tag, " valid"}, 32'(addr_valid), 32'd1);
        chk({tag, " addr"}, 32'(addr_out), 32'(a));
        chk({tag, " seg"}, 32'(addr_seg), 32'(s));
    endtask

    task automatic t_reset();
        chk("R1 valid in reset", 32'(addr_valid), 0);
        chk("R1 addr in reset", 32'(addr_out), 0);
        chk("R1 seg in reset", 32'(addr_seg), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(addr_valid), 0);
        req(16'h1234, 2'd3, 1'b0, 1'b0);
        expect_out("R1 cleared data seg", 20'h01234, 2'd1);
    endtask

    task automatic t_basic();
        wr_seg(2'd1, 16'h1234);
        req(16'h5678, 2'd3, 1'b0, 1'b0);
        expect_out("R2 R7 data default", 20'h179B8, 2'd1);
        req(16'h0010, 2'd3, 1'b0, 1'b0);
        expect_out("R2 second pattern", phys(16'h1234, 16'h0010), 2'd1);
    endtask

    task automatic t_wrap();
        wr_seg(2'd1, 16'hFFFF);
        req(16'h4336, 2'd3, 1'b0, 1'b0);
        expect_out("R3 wrap", 20'h04326, 2'd1);
        req(16'hFFFF, 2'd3, 1'b0, 1'b0);
        expect_out("R3 max wrap", 20'h0FFEF, 2'd1);
    endtask

    task automatic t_alias();
        wr_seg(2'd1, 16'h1DDD); req(16'h0100, 2'd3, 1'b0, 1'b0);
        expect_out("R4 alias a", 20'h1DED0, 2'd1);
        wr_seg(2'd1, 16'h1DED); req(16'h0000, 2'd3, 1'b0, 1'b0);
        expect_out("R4 alias b", 20'h1DED0, 2'd1);
        wr_seg(2'd1, 16'h1DCD); req(16'h0200, 2'd3, 1'b0, 1'b0);
        expect_out("R4 alias c", 20'h1DED0, 2'd1);
    endtask

    task automatic t_fetch();
        wr_seg(2'd0, 16'h0700);
        req(16'h0010, 2'd0, 1'b0, 1'b0);
        expect_out("R5 R9 fetch code", 20'h07010, 2'd0);
        wr_seg(2'd3, 16'h5000);
        req(16'h0010, 2'd0, 1'b1, 1'b1);
        expect_out("R5 fetch ignores override", 20'h07010, 2'd0);
    endtask

    task automatic t_stack();
        wr_seg(2'd2, 16'h3000);
        req(16'hFFFE, 2'd1, 1'b0, 1'b0);
        expect_out("R6 stack ptr", 20'h3FFFE, 2'd2);
        req(16'h0004, 2'd2, 1'b0, 1'b0);
        expect_out("R6 base ptr", 20'h30004, 2'd2);
    endtask

    task automatic t_override();
        wr_seg(2'd1, 16'h1234);
        wr_seg(2'd3, 16'h5000);
        req(16'h0010, 2'd3, 1'b1, 1'b1);
        expect_out("R8 extra override", 20'h50010, 2'd3);
        req(16'h0020, 2'd1, 1'b1, 1'b0);
        expect_out("R8 stack to data", 20'h12360, 2'd1);
        req(16'h0030, 2'd2, 1'b1, 1'b1);
        expect_out("R8 base to extra", 20'h50030, 2'd3);
    endtask

    task automatic t_same_cycle();
        wr_seg(2'd1, 16'h1000);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h2000;
        req_valid = 1'b1; req_offset = 16'h0000; req_src = 2'd3;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_out("R10 old value same edge", 20'h10000, 2'd1);
        req(16'h0000, 2'd3, 1'b0, 1'b0);
        expect_out("R10 new value later", 20'h20000, 2'd1);
    endtask

    task automatic t_idle();
        logic [19:0] last_a;
        logic [1:0]  last_s;
        req(16'h0044, 2'd1, 1'b0, 1'b0);
        last_a = addr_out; last_s = addr_seg;
        wr_seg(2'd2, 16'h7777);
        @(negedge clk);
        chk("R11 valid low when idle", 32'(addr_valid), 0);
        chk("R11 addr held", 32'(addr_out), 32'(last_a));
        chk("R11 seg held", 32'(last_s), 32'(addr_seg));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_alias();
        t_fetch();
        t_stack();
        t_override();
        t_same_cycle();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule